// File: doc/BRIEF.md
# Shared-Cache Event Counter Block

This block watches a shared cache for performance events and counts them for software. Every cycle the cache presents a 256-bit pulse vector, one bit per event code. Eight 48-bit counters each pick one code through an 8-bit select field and add one on every cycle in which that code's pulse is high. Counting only happens while a single global run bit is set and the counter's own enable bit is set.

When a counter wraps from its all-ones value back to zero it raises its own overflow flag. The flags feed one level-sensitive interrupt line through a per-counter mask in which a set bit blocks the flag. Software clears a flag by writing a one to its bit in a separate clear register. All control, selects, counters and interrupt registers sit behind a simple single-cycle register port with a 64-bit data path. The 32-bit registers use its low half.

Top module: `llc_event_counter`

## Requirements
- R1: After reset, every counter, the run bit, the enable bitmap and the overflow flags read 0, the mask register reads 0xFF (all masked), both select registers read 0xFFFFFFFF, and irq is low.
- R2: Counter i is read and written as a 64-bit word at byte offset 0x100 + 8*i. A write preloads bits 47:0 and wins over an event counted in the same cycle. Bits 63:48 always read zero and ignore writes.
- R3: The select field of counter i is byte lane (i mod 4), bits 8*(i mod 4)+7 down to 8*(i mod 4), of the 32-bit select register at 0x040 (counters 0 to 3) or 0x044 (counters 4 to 7). Both registers read back what was written.
- R4: While run bit 17 of the control register (offset 0x000) is set and bit i of the enable register (offset 0x010) is set, counter i adds exactly 1 in each cycle where evt_pulse[select code of counter i] is high, and holds otherwise.
- R5: A counter whose select code is 0xFF never advances, even when evt_pulse[255] is high.
- R6: While the run bit is clear, no counter advances, whatever the enable bits and pulses.
- R7: A counter whose enable bit is clear does not advance while the run bit is set.
- R8: When counter i counts from 2^48-1 it becomes 0 and bit i of the status register (offset 0x024) becomes 1.
- R9: Writing a 1 to bit i of the clear register (offset 0x028) clears status bit i. Writing 0 bits has no effect, writes to the status register itself are ignored, and a wrap in the same cycle as a clear leaves the flag set.
- R10: irq is high exactly when some status bit i is 1 and bit i of the mask register (offset 0x020) is 0. A mask bit of 1 blocks that flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Register byte address |
| wdata | input | 64 | Write data; 32-bit registers use bits 31:0 |
| rdata | output | 64 | Read data for addr, combinational |
| evt_pulse | input | 256 | Event pulses, bit n carries event code n |
| irq | output | 1 | Level overflow interrupt |

## Verification
A table of runs drives each counter in turn with a pulse on its own code, on a neighbouring code, and on the reserved code 0xFF. This separates a counter that decodes its byte lane correctly from one that reads a wrong lane or counts on any pulse. The run bit and the enable bit are then each cleared on their own, so that a gate which ignores either one shows up. A preload to all ones followed by one event shows the wrap and the flag setting. Masking, a zero clear, a write to the status register and a one clear then tell the mask polarity and the write-one-to-clear behaviour apart from plain overwrite.

// File: rtl/llc_event_counter.sv
module llc_event_counter #(
  parameter int ADDR_W  = 12,
  parameter int CNT_W   = 48,
  parameter int NUM_CNT = 8,
  parameter int RUN_BIT = 17,
  parameter int CTRL_A  = 'h000,
  parameter int EN_A    = 'h010,
  parameter int MASK_A  = 'h020,
  parameter int STAT_A  = 'h024,
  parameter int CLR_A   = 'h028,
  parameter int SEL_A   = 'h040,
  parameter int CNT_A   = 'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [63:0]       wdata,
  output logic [63:0]       rdata,
  input  logic [255:0]      evt_pulse,
  output logic              irq
);
  localparam int SEL_REGS = NUM_CNT / 4;
  localparam logic [7:0] NO_EVT = 8'hFF;

  logic                           run_q;
  logic [NUM_CNT-1:0]             en_q, mask_q, status_q;
  logic [NUM_CNT-1:0][7:0]        sel_q;
  logic [NUM_CNT-1:0][CNT_W-1:0]  cnt_q;
  logic [NUM_CNT-1:0]             hit, wrap, cnt_wr;
  logic [SEL_REGS-1:0]            sel_wr;
  logic                           unused_hi;

  assign unused_hi = ^wdata[63:CNT_W];

  wire wr_ctrl = wr_en && addr == ADDR_W'(CTRL_A);
  wire wr_en_r = wr_en && addr == ADDR_W'(EN_A);
  wire wr_mask = wr_en && addr == ADDR_W'(MASK_A);
  wire wr_clr  = wr_en && addr == ADDR_W'(CLR_A);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      en_q   <= '0;
      mask_q <= '1;
    end else begin
      if (wr_ctrl) run_q  <= wdata[RUN_BIT];
      if (wr_en_r) en_q   <= wdata[NUM_CNT-1:0];
      if (wr_mask) mask_q <= wdata[NUM_CNT-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else status_q <= (status_q & ~(wr_clr ? wdata[NUM_CNT-1:0] : '0)) | wrap;
  end

  assign irq = |(status_q & ~mask_q);

  for (genvar r = 0; r < SEL_REGS; r++) begin : g_sel
    assign sel_wr[r] = wr_en && addr == ADDR_W'(SEL_A + 4 * r);
    for (genvar b = 0; b < 4; b++) begin : g_lane
      always_ff @(posedge clk) begin
        if (!rst_n) sel_q[4*r+b] <= NO_EVT;
        else if (sel_wr[r]) sel_q[4*r+b] <= wdata[8*b +: 8];
      end
    end
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    assign cnt_wr[i] = wr_en && addr == ADDR_W'(CNT_A + 8 * i);
    assign hit[i]    = run_q && en_q[i] && sel_q[i] != NO_EVT && evt_pulse[sel_q[i]];
    assign wrap[i]   = hit[i] && !cnt_wr[i] && (&cnt_q[i]);
    always_ff @(posedge clk) begin
      if (!rst_n) cnt_q[i] <= '0;
      else if (cnt_wr[i]) cnt_q[i] <= wdata[CNT_W-1:0];
      else if (hit[i]) cnt_q[i] <= cnt_q[i] + 1'b1;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(CTRL_A)) rdata[RUN_BIT] = run_q;
    if (addr == ADDR_W'(EN_A))   rdata[NUM_CNT-1:0] = en_q;
    if (addr == ADDR_W'(MASK_A)) rdata[NUM_CNT-1:0] = mask_q;
    if (addr == ADDR_W'(STAT_A)) rdata[NUM_CNT-1:0] = status_q;
    for (int r = 0; r < SEL_REGS; r++)
      if (addr == ADDR_W'(SEL_A + 4 * r))
        for (int b = 0; b < 4; b++) rdata[8*b +: 8] = sel_q[4*r+b];
    for (int i = 0; i < NUM_CNT; i++)
      if (addr == ADDR_W'(CNT_A + 8 * i)) rdata[CNT_W-1:0] = cnt_q[i];
  end
endmodule

// File: rtl/llc_event_counter_chk.sv
module llc_event_counter_chk #(
  parameter int ADDR_W  = 12,
  parameter int CNT_W   = 48,
  parameter int NUM_CNT = 8,
  parameter int CLR_A   = 'h028
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          wr_en,
  input logic [ADDR_W-1:0]             addr,
  input logic [63:0]                   wdata,
  input logic                          irq,
  input logic                          run,
  input logic [NUM_CNT-1:0]            mask,
  input logic [NUM_CNT-1:0]            status,
  input logic [NUM_CNT-1:0][7:0]       sel,
  input logic [NUM_CNT-1:0][CNT_W-1:0] cnt
);
  // R6
  halted_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !wr_en |=> cnt == $past(cnt));

  // R10
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '1 || status == '0) |-> !irq);

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_c
    // R5
    no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel[i] == 8'hFF && !wr_en |=> $stable(cnt[i]));
    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_en) && cnt[i] != $past(cnt[i]) |-> cnt[i] == $past(cnt[i]) + CNT_W'(1));
    // R8
    overflow_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[i]) |-> $past(cnt[i]) == '1 && cnt[i] == '0);
    // R9
    clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(status[i]) |-> $past(wr_en && addr == ADDR_W'(CLR_A) && wdata[i]));
  end
endmodule

bind llc_event_counter llc_event_counter_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .NUM_CNT(NUM_CNT), .CLR_A(CLR_A)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .irq(irq), .run(run_q), .mask(mask_q), .status(status_q),
  .sel(sel_q), .cnt(cnt_q)
);

// File: tb/sim_llc_event_counter.sv
`timescale 1ns/1ps
module sim_llc_event_counter;
  localparam logic [11:0] CTRL = 12'h000, EN = 12'h010, MASK = 12'h020,
                          STAT = 12'h024, CLR = 12'h028, SEL = 12'h040, CNT = 12'h100;
  localparam logic [63:0] RUN = 64'h2_0000;

  // idx, select, pulse code, pulse cycles, expected count
  localparam logic [39:0] VEC [8] = '{
    {8'd0, 8'h00, 8'h00, 8'd5, 8'd5},
    {8'd1, 8'h01, 8'h02, 8'd4, 8'd0},
    {8'd2, 8'h29, 8'h29, 8'd3, 8'd3},
    {8'd3, 8'h40, 8'h40, 8'd7, 8'd7},
    {8'd4, 8'h20, 8'h20, 8'd2, 8'd2},
    {8'd5, 8'hFF, 8'hFF, 8'd6, 8'd0},
    {8'd6, 8'h42, 8'h42, 8'd1, 8'd1},
    {8'd7, 8'h23, 8'h22, 8'd3, 8'd0}
  };

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [11:0] addr = '0;
  logic [63:0] wdata = '0, rdata, v;
  logic [255:0] evt_pulse = '0;
  logic irq;
  logic [7:0] shs [8];
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  llc_event_counter u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .evt_pulse(evt_pulse), .irq(irq));

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [63:0] d);
    addr = a; #1 d = rdata;
  endtask

  task automatic pulse(input int code, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); evt_pulse = '0; evt_pulse[code] = 1'b1;
    end
    @(negedge clk); evt_pulse = '0;
  endtask

  task automatic put_sel(input int i, input logic [7:0] c);
    shs[i] = c;
    wr(SEL + 12'(4 * (i / 4)), {32'h0, shs[4*(i/4)+3], shs[4*(i/4)+2], shs[4*(i/4)+1], shs[4*(i/4)]});
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) shs[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(CTRL, v); chk("R1 ctrl", v, 0);
    rd(EN, v);   chk("R1 enable", v, 0);
    rd(MASK, v); chk("R1 mask", v, 64'hFF);
    rd(STAT, v); chk("R1 status", v, 0);
    rd(SEL + 12'd4, v); chk("R1 select", v, 64'hFFFF_FFFF);
    rd(CNT + 12'd56, v); chk("R1 counter", v, 0);
    chk("R1 irq", {63'h0, irq}, 0);

    wr(CTRL, RUN);
    foreach (VEC[e]) begin
      automatic int idx = VEC[e][39:32];
      automatic logic [7:0] s = VEC[e][31:24], p = VEC[e][23:16];
      automatic int n = VEC[e][15:8];
      automatic logic [63:0] exp = (s == p && s != 8'hFF) ? 64'(n) : 64'd0;
      put_sel(idx, s);
      wr(CNT + 12'(8 * idx), 0);
      wr(EN, 64'(1) << idx);
      pulse(p, n);
      rd(CNT + 12'(8 * idx), v);
      chk("R4 R5 table count", v, exp);
      chk("R4 table vector", v, 64'(VEC[e][7:0]));
    end
    rd(SEL, v);         chk("R3 select lo", v, {32'h0, shs[3], shs[2], shs[1], shs[0]});
    rd(SEL + 12'd4, v); chk("R3 select hi", v, {32'h0, shs[7], shs[6], shs[5], shs[4]});

    wr(CNT + 12'd16, 64'hFFFF_0000_0000_0005);
    rd(CNT + 12'd16, v); chk("R2 upper bits", v, 64'h5);

    wr(EN, 64'h1);
    evt_pulse[0] = 1'b1;
    wr(CNT, 64'd100);
    evt_pulse = '0;
    rd(CNT, v); chk("R2 write wins", v, 64'd100);

    wr(CTRL, 0);
    pulse(0, 3);
    rd(CNT, v); chk("R6 run clear", v, 64'd100);
    wr(CTRL, RUN); wr(EN, 0);
    pulse(0, 3);
    rd(CNT, v); chk("R7 enable clear", v, 64'd100);
    wr(EN, 64'h1);
    pulse(0, 2);
    rd(CNT, v); chk("R4 resume", v, 64'd102);

    wr(EN, 64'h8);
    wr(CNT + 12'd24, 64'hFFFF_FFFF_FFFF);
    pulse(8'h40, 1);
    rd(CNT + 12'd24, v); chk("R8 wrap", v, 0);
    rd(STAT, v); chk("R8 flag", v, 64'h8);
    chk("R10 masked", {63'h0, irq}, 0);
    wr(MASK, 64'hF7);
    chk("R10 unmasked", {63'h0, irq}, 1);
    wr(CLR, 0);
    rd(STAT, v); chk("R9 zero clear", v, 64'h8);
    wr(STAT, 0);
    rd(STAT, v); chk("R9 status write", v, 64'h8);
    wr(CLR, 64'h8);
    rd(STAT, v); chk("R9 one clear", v, 0);
    chk("R10 cleared", {63'h0, irq}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule